// File: doc/BRIEF.md
# Port Supply Discharge-to-Safe Supervisor

This block sequences the controlled draining of a 5 V port supply rail once the source has gone away. A one-cycle detach event arms it. It turns on a discharge-enable output only when no source is present and no higher-priority protection is active. Fast short, over-voltage and thermal faults all outrank discharge. While discharge runs, the block counts millisecond ticks until a synchronized safe-level comparator (rail at or below 0.3 V) has been qualified.

The elapsed time is compared with a programmable budget, normally 100 to 300 ms. The block then latches the time as telemetry along with a pass bit for the reconnect gate. If the rail is still above the safe level when the budget runs out, the block raises a slow-discharge flag. The retry logic reads this flag as a block on any further retry or re-enable. The flag holds until a synchronous clear.

Top module: `vbus_dis_sup`

## Requirements
- R1: `dis_en` is high only in the cycles after a detach event has started a measurement. It is low in any cycle that follows a cycle with `src_present` high. Out of reset and after a finished measurement, it is low.
- R2: While any of `fault_short`, `fault_ovp` or `fault_therm` is high, `dis_en` is low one cycle later. A detach event that arrives during a fault waits, with discharge held off, and discharge starts once every fault has cleared. A fault during discharge does not stop the time count.
- R3: Elapsed time is counted in `ms_tick` pulses from the start of discharge by a 10-bit counter that saturates at 1023 and never wraps.
- R4: `rail_safe_raw` (1 = rail at or below the safe level) passes through two flip-flops. The rail counts as safe only after the synchronized bit reads 1 on 2 consecutive ticks. A tick that reads 0 restarts the qualification.
- R5: If qualification completes on tick number N and N ≤ `budget_ms`, then after that tick `t_meas` = N, `gate_pass` = 1, `res_valid` = 1, `slow_block` = 0, and `dis_en` drops. Reaching the safe level is checked before expiry on the same tick.
- R6: If tick number N reaches `budget_ms` (N ≥ `budget_ms`) without qualification, the outcome is a failure: `t_meas` = 1023, `gate_pass` = 0, `slow_block` = 1, `res_valid` = 1, and `dis_en` drops.
- R7: A detach event that arrives while a measurement is pending or running is ignored. The time count is not restarted.
- R8: While `slow_block` is high, detach events are ignored and the results are held. After a passing result, a new detach event starts a new measurement and clears `res_valid` and `gate_pass`.
- R9: If `src_present` rises while a measurement is pending or running, the measurement is abandoned. `dis_en` drops, and `res_valid` stays 0.
- R10: A synchronous `clr` pulse sets `t_meas` to 0, clears `res_valid`, `gate_pass` and `slow_block`, stops discharge, and returns the block to idle.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of results and status |
| src_detach_evt | input | 1 | One-cycle pulse: source removed |
| src_present | input | 1 | Level: a source drives the rail |
| fault_short | input | 1 | Fast-short protection active |
| fault_ovp | input | 1 | Over-voltage protection active |
| fault_therm | input | 1 | Thermal protection active |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| rail_safe_raw | input | 1 | Asynchronous comparator, 1 = rail at or below safe level |
| budget_ms | input | 10 | Discharge time budget in ms |
| dis_en | output | 1 | Discharge path enable |
| res_valid | output | 1 | A measurement result is latched |
| gate_pass | output | 1 | Reconnect gate passed |
| slow_block | output | 1 | Slow discharge seen; retries blocked |
| t_meas | output | 10 | Latched time to safe level in ms, 1023 = timeout |

## Verification
The assertions assume that `ms_tick` and `src_detach_evt` are single-cycle pulses and that `budget_ms` holds steady while a measurement runs. The stimulus drives every input at the falling clock edge, issues ticks as one-cycle pulses with three idle cycles between them, and changes the budget only while the block is idle or cleared. The three idle cycles also give the two-stage synchronizer time to settle before each tick, so every tick sees a comparator value that the bench has chosen.

// File: rtl/vdis_pkg.sv
package vdis_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } dis_state_t;

  // one step of a counter that sticks at lim
  function automatic int unsigned sat_step(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // budget has run out once elapsed ticks reach it, or the count is pinned
  function automatic logic budget_spent(int unsigned e, int unsigned budget, int unsigned lim);
    return (e >= budget) || (e >= lim);
  endfunction

endpackage

// File: rtl/vdis_sync.sv
module vdis_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vdis_qualify.sv
module vdis_qualify #(
  parameter int QUAL_N = 2,
  localparam int QW = $clog2(QUAL_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  input  logic tick,
  input  logic low_s,
  output logic hit
);
  logic [QW-1:0] run_cnt;
  localparam logic [QW-1:0] CNT_TOP = QW'(QUAL_N);
  localparam logic [QW-1:0] CNT_PRE = QW'(QUAL_N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (restart)          run_cnt <= '0;
    else if (en && tick) begin
      if (!low_s)              run_cnt <= '0;
      else if (run_cnt < CNT_TOP) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign hit = en && tick && low_s && (run_cnt >= CNT_PRE);

  // R4: a qualifying tick is never the first safe reading after an unsafe one
  assert_qual_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !low_s) |=> (run_cnt == '0));
endmodule

// File: rtl/vdis_timer.sv
module vdis_timer #(
  parameter int TIME_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              en,
  input  logic              tick,
  output logic [TIME_W-1:0] elapsed,
  output logic [TIME_W-1:0] elapsed_nx
);
  import vdis_pkg::*;
  localparam int unsigned TMAX = (1 << TIME_W) - 1;

  assign elapsed_nx = TIME_W'(sat_step(int'(elapsed), TMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          elapsed <= '0;
    else if (restart)    elapsed <= '0;
    else if (en && tick) elapsed <= elapsed_nx;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && elapsed == TIME_W'(TMAX)) |=> (elapsed == TIME_W'(TMAX)));

  assert_no_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (elapsed >= $past(elapsed)));
endmodule

// File: rtl/vbus_dis_sup.sv
module vbus_dis_sup #(
  parameter int TIME_W = 10,
  parameter int QUAL_N = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              src_detach_evt,
  input  logic              src_present,
  input  logic              fault_short,
  input  logic              fault_ovp,
  input  logic              fault_therm,
  input  logic              ms_tick,
  input  logic              rail_safe_raw,
  input  logic [TIME_W-1:0] budget_ms,
  output logic              dis_en,
  output logic              res_valid,
  output logic              gate_pass,
  output logic              slow_block,
  output logic [TIME_W-1:0] t_meas
);
  import vdis_pkg::*;
  localparam int unsigned TMAX = (1 << TIME_W) - 1;
  localparam logic [TIME_W-1:0] TMAX_V = TIME_W'(TMAX);

  dis_state_t state, state_n;
  logic fault_any, rail_low_s, hit, start_run, start_ok, running;
  logic ev_pass, ev_fail, ev_abort;
  logic [TIME_W-1:0] elapsed, elapsed_nx;

  assign fault_any = fault_short | fault_ovp | fault_therm;
  assign running   = (state == ST_RUN);

  vdis_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rail_safe_raw), .q(rail_low_s)
  );

  vdis_qualify #(.QUAL_N(QUAL_N)) u_qual (
    .clk(clk), .rst_n(rst_n), .restart(start_run), .en(running),
    .tick(ms_tick), .low_s(rail_low_s), .hit(hit)
  );

  vdis_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(start_run), .en(running),
    .tick(ms_tick), .elapsed(elapsed), .elapsed_nx(elapsed_nx)
  );

  assign start_ok = src_detach_evt && !src_present &&
                    ((state == ST_IDLE) || (state == ST_DONE && !slow_block));
  assign start_run = (state == ST_PEND) && !src_present && !fault_any && !clr;
  assign ev_abort  = ((state == ST_PEND) || running) && src_present && !clr;
  assign ev_pass   = running && !src_present && !clr && hit;
  assign ev_fail   = running && !src_present && !clr && ms_tick && !hit &&
                     budget_spent(int'(elapsed_nx), int'(budget_ms), TMAX);

  always_comb begin
    state_n = state;
    if (clr) state_n = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (start_ok) state_n = ST_PEND;
        ST_PEND: begin
          if (ev_abort)       state_n = ST_IDLE;
          else if (start_run) state_n = ST_RUN;
        end
        ST_RUN: begin
          if (ev_abort)                state_n = ST_IDLE;
          else if (ev_pass || ev_fail) state_n = ST_DONE;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      dis_en     <= 1'b0;
      res_valid  <= 1'b0;
      gate_pass  <= 1'b0;
      slow_block <= 1'b0;
      t_meas     <= '0;
    end else begin
      state  <= state_n;
      dis_en <= (state_n == ST_RUN) && !fault_any && !src_present;
      if (clr) begin
        res_valid  <= 1'b0;
        gate_pass  <= 1'b0;
        slow_block <= 1'b0;
        t_meas     <= '0;
      end else if (start_ok) begin
        res_valid <= 1'b0;
        gate_pass <= 1'b0;
        t_meas    <= '0;
      end else if (ev_pass) begin
        res_valid <= 1'b1;
        gate_pass <= 1'b1;
        t_meas    <= elapsed_nx;
      end else if (ev_fail) begin
        res_valid  <= 1'b1;
        gate_pass  <= 1'b0;
        slow_block <= 1'b1;
        t_meas     <= TMAX_V;
      end
    end
  end

  assert_no_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en |-> $past(!src_present));

  assert_fault_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_any) |-> !dis_en);

  assert_pass_in_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass |=> (gate_pass && res_valid && !dis_en && t_meas <= $past(budget_ms)));

  assert_pass_on_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass |-> rail_low_s);

  assert_slow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_block |-> (res_valid && !gate_pass && t_meas == TMAX_V));

  assert_block_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_block && !clr) |=> (slow_block && !dis_en));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!res_valid && !gate_pass && !slow_block && t_meas == '0 && !dis_en));
endmodule

// File: tb/vbus_dis_sup_bench.sv
module vbus_dis_sup_bench;
  localparam int CLK_P = 10;
  localparam int TMAX = 1023;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, det = 1'b0, src = 1'b0;
  logic f_sc = 1'b0, f_ov = 1'b0, f_th = 1'b0, tick = 1'b0, rail = 1'b0;
  logic [9:0] budget = 10'd5;
  logic dis_en, res_valid, gate_pass, slow_block;
  logic [9:0] t_meas;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  vbus_dis_sup u_vbus_dis_sup (
    .clk(clk), .rst_n(rst_n), .clr(clr), .src_detach_evt(det), .src_present(src),
    .fault_short(f_sc), .fault_ovp(f_ov), .fault_therm(f_th), .ms_tick(tick),
    .rail_safe_raw(rail), .budget_ms(budget), .dis_en(dis_en), .res_valid(res_valid),
    .gate_pass(gate_pass), .slow_block(slow_block), .t_meas(t_meas)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    cyc(3);
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  task automatic detach();
    det = 1'b1; cyc(1); det = 1'b0; cyc(1);
  endtask

  task automatic check_result(string req, int t, int pass, int slow);
    chk({req, " valid"}, int'(res_valid), 1);
    chk({req, " t_meas"}, int'(t_meas), t);
    chk({req, " gate_pass"}, int'(gate_pass), pass);
    chk({req, " slow_block"}, int'(slow_block), slow);
    chk({req, " dis_en off"}, int'(dis_en), 0);
  endtask

  initial begin
    cyc(3);
    // R11 reset state
    chk("R11 dis_en", int'(dis_en), 0);
    chk("R11 res_valid", int'(res_valid), 0);
    chk("R11 slow_block", int'(slow_block), 0);
    chk("R11 t_meas", int'(t_meas), 0);
    rst_n = 1'b1;
    cyc(2);

    // R1: source still present, detach ignored
    src = 1'b1; detach(); cyc(2);
    chk("R1 no enable with source", int'(dis_en), 0);
    src = 1'b0; cyc(2);

    // R5/R6 sweep: budgets 1..6, safe from tick j; reached at j+1
    for (int b = 1; b <= 6; b++) begin
      for (int j = 1; j <= 8; j++) begin
        int r, fin, k;
        pulse_clr();
        rail = 1'b0; budget = 10'(b);
        detach();
        chk("R1 enable after detach", int'(dis_en), 1);
        r = j + 1;
        fin = (r <= b) ? r : b;
        k = 0;
        while (k < fin) begin
          k++;
          if (k == j) rail = 1'b1;
          do_tick();
          if (k < fin) chk("R5 still running", int'(dis_en), 1);
        end
        if (r <= b) check_result("R5 pass", r, 1, 0);
        else        check_result("R6 slow", TMAX, 0, 1);
        rail = 1'b0;
      end
    end

    // R4: one unsafe tick restarts qualification
    pulse_clr(); budget = 10'd10; detach();
    rail = 1'b1; do_tick();
    rail = 1'b0; do_tick();
    rail = 1'b1; do_tick();
    chk("R4 not yet qualified", int'(res_valid), 0);
    do_tick();
    check_result("R4 requalified", 4, 1, 0);

    // R8: new detach after pass restarts and clears result
    rail = 1'b0; detach();
    chk("R8 restart clears valid", int'(res_valid), 0);
    chk("R8 restart enables", int'(dis_en), 1);
    // R7: detach during run ignored (no timer restart)
    do_tick(); do_tick();
    detach();
    rail = 1'b1; do_tick();
    do_tick();
    check_result("R7 detach ignored", 4, 1, 0);
    rail = 1'b0;

    // R2: fault at detach holds discharge off; fault mid-run keeps counting
    pulse_clr(); budget = 10'd20;
    f_ov = 1'b1; detach(); cyc(4);
    chk("R2 held by fault", int'(dis_en), 0);
    f_ov = 1'b0; cyc(2);
    chk("R2 starts after fault clears", int'(dis_en), 1);
    do_tick();
    f_th = 1'b1; cyc(1);
    chk("R2 fault mid-run drops enable", int'(dis_en), 0);
    do_tick(); do_tick();
    f_th = 1'b0; cyc(1);
    chk("R2 enable back", int'(dis_en), 1);
    rail = 1'b1; do_tick(); do_tick();
    check_result("R2 time kept during fault", 5, 1, 0);
    rail = 1'b0;

    // R9: source returns mid-run aborts
    pulse_clr(); budget = 10'd3; detach();
    do_tick();
    src = 1'b1; cyc(1);
    chk("R9 abort drops enable", int'(dis_en), 0);
    do_tick(); do_tick(); do_tick();
    chk("R9 no result", int'(res_valid), 0);
    chk("R9 no slow flag", int'(slow_block), 0);
    src = 1'b0;

    // R8: slow fail blocks later detach
    pulse_clr(); budget = 10'd2; detach();
    do_tick(); do_tick();
    check_result("R6 fail", TMAX, 0, 1);
    detach(); cyc(2);
    chk("R8 blocked detach dis_en", int'(dis_en), 0);
    do_tick(); do_tick();
    check_result("R8 held result", TMAX, 0, 1);

    // R10 clear
    pulse_clr();
    chk("R10 valid", int'(res_valid), 0);
    chk("R10 slow", int'(slow_block), 0);
    chk("R10 t_meas", int'(t_meas), 0);
    detach();
    chk("R10 detach works after clear", int'(dis_en), 1);
    pulse_clr();
    chk("R10 clear stops discharge", int'(dis_en), 0);

    // R3 saturation: budget 1023, rail never safe
    budget = 10'd1023; detach();
    for (int k = 1; k < TMAX; k++) do_tick();
    chk("R3 still running at 1022", int'(res_valid), 0);
    do_tick();
    check_result("R3 saturated timeout", TMAX, 0, 1);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule